// File: doc/BRIEF.md
# Three-Rail Enable and System-Ready Controller

This block is the digital control core of a power manager with two switching rails and one linear rail. It works out which rails to switch on from three sources. The first is a set of per-rail enable bits. The second is a combined enable bit, which runs a built-in sequencer. The third is an external enable pin. A latched over-temperature status forces every rail off until software clears it.

The block also drives an active-high system-ready output. This output rises once every rail that is not masked reports power-good. It may do so only when software has allowed power-good gating or when the enable pin is high.

Each rail has a power-good mask register. Its reset value comes from a parameter that stands in for factory-programmed defaults. The ready output is registered. It changes only after the enable sources have been steady for a full cycle, so a burst of control writes cannot make it glitch.

Top module: `pwr_rail_ctrl`

## Requirements
- R1: After reset, `rail_on`, `ready_out`, `therm_latched` and `pgood_status` are 0, and `pgood_mask` equals the parameter `MASK_DEFAULT`.
- R2: When any bit of `rail_en_req` is 1, `en_pin` is low and no thermal event is latched, `rail_on` equals `rail_en_req` one cycle later, and `all_en_req` has no effect. The bit positions are: bit 0 is switching rail A, bit 1 is switching rail B, bit 2 is the linear rail.
- R3: While `en_pin` is high and no thermal event is latched, `rail_on` is 3'b111 one cycle later, whatever the enable bits hold. The sequencer is bypassed.
- R4: When `all_en_req` is 1, every bit of `rail_en_req` is 0, `en_pin` is low and no thermal event is latched, the sequencer switches the rails on in this order: rail A, then rail B, then the linear rail.
- R4 (timing): Rail A appears in `rail_on` 2 cycles after the request. Each later rail follows `step_gap`+1 cycles after the one before it.
- R5: When the sequencer's request is withdrawn, or when a thermal event latches, the sequencer returns to all-off. A later request starts again from rail A.
- R6: `therm_event` sets `therm_latched` one cycle later. Only `therm_clr` with no event in the same cycle clears it, and an event wins over a clear in the same cycle.
- R7: While `therm_latched` is 1, `rail_on` is 0 from the next cycle on, for every enable source.
- R8: `pgood_status` is `pgood_in` delayed by one register.
- R8 (ready rule): `ready_out` may be 1 only if `force_ready` or `en_pin` is 1 and, for every rail, `pgood_status` or `pgood_mask` is 1.
- R9: `ready_out` takes a new value only at an edge where the enable sources (`en_pin`, `force_ready`, `all_en_req`, `rail_en_req`) match their values from the previous edge. Otherwise it holds.
- R10: A cycle with `mask_wr` high loads `mask_wdata` into `pgood_mask` one cycle later. A bit of 1 means that rail's power-good is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rail_en_req | input | 3 | Per-rail enable bits |
| all_en_req | input | 1 | Combined enable, run through the sequencer |
| en_pin | input | 1 | External enable pin |
| force_ready | input | 1 | Allows power-good to drive the ready output |
| step_gap | input | GAP_W | Extra wait cycles between sequencer steps |
| pgood_in | input | 3 | Per-rail power-good from the regulators |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 3 | New mask value |
| therm_event | input | 1 | Over-temperature event pulse |
| therm_clr | input | 1 | Software clear of the thermal latch |
| rail_on | output | 3 | Per-rail enable to the regulators |
| ready_out | output | 1 | System-ready (shutdown release) |
| pgood_status | output | 3 | Registered power-good status |
| pgood_mask | output | 3 | Current power-good ignore mask |
| therm_latched | output | 1 | Latched thermal status |

## Verification
Most results are due one cycle after their stimulus:
- `rail_on` in direct mode and pin mode
- `therm_latched`
- `pgood_mask`
- `pgood_status`

Some results take longer:
- A latched thermal event reaches `rail_on` two cycles after the event pulse.
- Sequenced rails appear after 2, 2+(gap+1) and 2+2(gap+1) cycles.
- `ready_out` follows a power-good or mask change after two cycles, and follows an enable-source change after two cycles because of the stability rule.

Every stimulus task records its expected value together with the exact cycle in which it is due. The monitor compares it only in that cycle, half a period after the edge. The checks also sample the cycle just before each change is due, so that a result arriving too early is caught as well.

// File: rtl/pwr_rail_pkg.sv
package pwr_rail_pkg;

  localparam int NUM_RAILS = 3;
  localparam int STAGE_W   = $clog2(NUM_RAILS + 1);

  // Rails switched on by the sequencer at a given stage: the lowest
  // 'stage' rails, in fixed order A, B, linear.
  function automatic logic [NUM_RAILS-1:0] stage_rails(input logic [STAGE_W-1:0] stage);
    logic [NUM_RAILS-1:0] m;
    for (int i = 0; i < NUM_RAILS; i++) begin
      m[i] = (i < int'(stage));
    end
    return m;
  endfunction

  // Ready qualification: a gate source plus every rail good or masked.
  function automatic logic ready_qualify(input logic gate,
                                         input logic [NUM_RAILS-1:0] pg,
                                         input logic [NUM_RAILS-1:0] mask);
    return gate && (&(pg | mask));
  endfunction

  // Priority of enable sources: thermal block, pin, direct bits, sequencer.
  function automatic logic [NUM_RAILS-1:0] rail_select(input logic therm,
                                                       input logic pin,
                                                       input logic [NUM_RAILS-1:0] direct,
                                                       input logic [NUM_RAILS-1:0] seq);
    if (therm)        return '0;
    else if (pin)     return '1;
    else if (|direct) return direct;
    else              return seq;
  endfunction

endpackage

// File: rtl/prc_fault_regs.sv
module prc_fault_regs
  import pwr_rail_pkg::*;
#(
  parameter logic [NUM_RAILS-1:0] MASK_DEFAULT = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 therm_event,
  input  logic                 therm_clr,
  input  logic                 mask_wr,
  input  logic [NUM_RAILS-1:0] mask_wdata,
  output logic                 therm_q,
  output logic [NUM_RAILS-1:0] mask_q
);

  // Thermal latch: an event wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)           therm_q <= 1'b0;
    else if (therm_event) therm_q <= 1'b1;
    else if (therm_clr)   therm_q <= 1'b0;
  end

  // Per-rail ignore mask, reset from the parameter default.
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)       mask_q[g] <= MASK_DEFAULT[g];
      else if (mask_wr) mask_q[g] <= mask_wdata[g];
    end
  end

endmodule

// File: rtl/prc_sequencer.sv
module prc_sequencer
  import pwr_rail_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [GAP_W-1:0]     step_gap,
  output logic [NUM_RAILS-1:0] seq_rails,
  output logic                 step_fire
);

  localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(NUM_RAILS);

  logic [STAGE_W-1:0] stage;
  logic [GAP_W-1:0]   gap_cnt;

  // A step happens when the wait after the current stage is over.
  assign step_fire = go && (stage != '0) && (stage != LAST_STAGE) && (gap_cnt == step_gap);

  always_ff @(posedge clk) begin
    if (!rst_n || !go) begin
      stage   <= '0;
      gap_cnt <= '0;
    end else if (stage == '0) begin
      stage   <= STAGE_W'(1);
      gap_cnt <= '0;
    end else if (step_fire) begin
      stage   <= stage + STAGE_W'(1);
      gap_cnt <= '0;
    end else if (stage != LAST_STAGE) begin
      gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end

  assign seq_rails = stage_rails(stage);

endmodule

// File: rtl/prc_ready_gen.sv
module prc_ready_gen
  import pwr_rail_pkg::*;
#(
  parameter int SRC_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_W-1:0]     src,
  input  logic                 gate,
  input  logic [NUM_RAILS-1:0] pgood_in,
  input  logic [NUM_RAILS-1:0] mask,
  output logic [NUM_RAILS-1:0] pgood_q,
  output logic                 ready_q,
  output logic                 src_stable,
  output logic                 ready_cand
);

  logic [SRC_W-1:0] src_prev;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_pg
    always_ff @(posedge clk) begin
      if (!rst_n) pgood_q[g] <= 1'b0;
      else        pgood_q[g] <= pgood_in[g];
    end
  end

  assign src_stable = (src == src_prev);
  assign ready_cand = ready_qualify(gate, pgood_q, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_prev <= '0;
      ready_q  <= 1'b0;
    end else begin
      src_prev <= src;
      if (src_stable) ready_q <= ready_cand;
    end
  end

endmodule

// File: rtl/pwr_rail_ctrl.sv
module pwr_rail_ctrl
  import pwr_rail_pkg::*;
#(
  parameter int                   GAP_W        = 8,
  parameter logic [NUM_RAILS-1:0] MASK_DEFAULT = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] rail_en_req,
  input  logic                 all_en_req,
  input  logic                 en_pin,
  input  logic                 force_ready,
  input  logic [GAP_W-1:0]     step_gap,
  input  logic [NUM_RAILS-1:0] pgood_in,
  input  logic                 mask_wr,
  input  logic [NUM_RAILS-1:0] mask_wdata,
  input  logic                 therm_event,
  input  logic                 therm_clr,
  output logic [NUM_RAILS-1:0] rail_on,
  output logic                 ready_out,
  output logic [NUM_RAILS-1:0] pgood_status,
  output logic [NUM_RAILS-1:0] pgood_mask,
  output logic                 therm_latched
);

  localparam int SRC_W = NUM_RAILS + 3;

  logic                 therm_q;
  logic                 direct_mode;
  logic                 seq_go;
  logic                 step_fire;
  logic                 src_stable;
  logic                 ready_cand;
  logic [NUM_RAILS-1:0] seq_rails;
  logic [NUM_RAILS-1:0] rail_next;
  logic [SRC_W-1:0]     src_vec;

  prc_fault_regs #(.MASK_DEFAULT(MASK_DEFAULT)) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .therm_event(therm_event),
    .therm_clr  (therm_clr),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .therm_q    (therm_q),
    .mask_q     (pgood_mask)
  );

  // The combined enable counts only with all direct bits clear.
  assign direct_mode = |rail_en_req;
  assign seq_go      = all_en_req && !direct_mode && !en_pin && !therm_q;

  prc_sequencer #(.GAP_W(GAP_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (seq_go),
    .step_gap (step_gap),
    .seq_rails(seq_rails),
    .step_fire(step_fire)
  );

  assign rail_next = rail_select(therm_q, en_pin, rail_en_req, seq_rails);

  always_ff @(posedge clk) begin
    if (!rst_n) rail_on <= '0;
    else        rail_on <= rail_next;
  end

  assign src_vec = {en_pin, force_ready, all_en_req, rail_en_req};

  prc_ready_gen #(.SRC_W(SRC_W)) u_ready (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src_vec),
    .gate      (force_ready | en_pin),
    .pgood_in  (pgood_in),
    .mask      (pgood_mask),
    .pgood_q   (pgood_status),
    .ready_q   (ready_out),
    .src_stable(src_stable),
    .ready_cand(ready_cand)
  );

  assign therm_latched = therm_q;

endmodule

// File: rtl/pwr_rail_ctrl_chk.sv
module pwr_rail_ctrl_chk
  import pwr_rail_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_RAILS-1:0] rail_en_req,
  input logic                 en_pin,
  input logic                 force_ready,
  input logic                 therm_event,
  input logic [NUM_RAILS-1:0] rail_on,
  input logic                 ready_out,
  input logic                 therm_latched,
  input logic                 src_stable
);

  a_r7_therm_blocks_rails: assert property (@(posedge clk) disable iff (!rst_n)
    therm_latched |=> (rail_on == '0));

  a_r6_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    therm_event |=> therm_latched);

  a_r3_pin_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && !therm_latched) |=> (rail_on == '1));

  a_r2_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_pin && !therm_latched && (rail_en_req != '0)) |=> (rail_on == $past(rail_en_req)));

  a_r9_hold_unstable: assert property (@(posedge clk) disable iff (!rst_n)
    !src_stable |=> $stable(ready_out));

  a_r8_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_out) |-> $past(force_ready || en_pin));

endmodule

bind pwr_rail_ctrl pwr_rail_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rail_en_req  (rail_en_req),
  .en_pin       (en_pin),
  .force_ready  (force_ready),
  .therm_event  (therm_event),
  .rail_on      (rail_on),
  .ready_out    (ready_out),
  .therm_latched(therm_latched),
  .src_stable   (src_stable)
);

// File: tb/pwr_rail_ctrl_test.sv
`timescale 1ns/1ps
module pwr_rail_ctrl_test;

  localparam int         GAP_W   = 8;
  localparam logic [2:0] TB_MASK = 3'b100;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       rail_en_req = '0;
  logic             all_en_req = 1'b0;
  logic             en_pin = 1'b0;
  logic             force_ready = 1'b0;
  logic [GAP_W-1:0] step_gap = '0;
  logic [2:0]       pgood_in = '0;
  logic             mask_wr = 1'b0;
  logic [2:0]       mask_wdata = '0;
  logic             therm_event = 1'b0;
  logic             therm_clr = 1'b0;
  logic [2:0]       rail_on;
  logic             ready_out;
  logic [2:0]       pgood_status;
  logic [2:0]       pgood_mask;
  logic             therm_latched;

  pwr_rail_ctrl #(.GAP_W(GAP_W), .MASK_DEFAULT(TB_MASK)) uut (
    .clk(clk), .rst_n(rst_n), .rail_en_req(rail_en_req), .all_en_req(all_en_req),
    .en_pin(en_pin), .force_ready(force_ready), .step_gap(step_gap),
    .pgood_in(pgood_in), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .therm_event(therm_event), .therm_clr(therm_clr), .rail_on(rail_on),
    .ready_out(ready_out), .pgood_status(pgood_status), .pgood_mask(pgood_mask),
    .therm_latched(therm_latched)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Scoreboard queues: due cycle, kind, value, requirement tag.
  int    q_due[$];
  int    q_kind[$];
  int    q_val[$];
  string q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observed(input int kind);
    case (kind)
      0: return int'(rail_on);
      1: return int'(ready_out);
      2: return int'(therm_latched);
      3: return int'(pgood_mask);
      default: return int'(pgood_status);
    endcase
  endfunction

  // Expected sequencer arrival of rail k, in cycles after the request.
  function automatic int seq_lat(input int k, input int gap);
    return 2 + k * (gap + 1);
  endfunction

  // Monitor: compare every item whose due cycle has come.
  always @(negedge clk) begin
    for (int i = q_due.size() - 1; i >= 0; i--) begin
      if (q_due[i] == cyc) begin
        n_cmp++;
        if (observed(q_kind[i]) != q_val[i]) begin
          n_bad++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                   q_req[i], q_kind[i], cyc, observed(q_kind[i]), q_val[i]);
        end
        q_due.delete(i); q_kind.delete(i); q_val.delete(i); q_req.delete(i);
      end
    end
  end

  task automatic push_exp(input int kind, input int val, input int lat, input string req);
    q_due.push_back(cyc + lat);
    q_kind.push_back(kind);
    q_val.push_back(val);
    q_req.push_back(req);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    wait_n(3);
    rst_n = 1'b1;
    // R1 reset state
    push_exp(0, 0, 1, "R1");
    push_exp(1, 0, 1, "R1");
    push_exp(2, 0, 1, "R1");
    push_exp(3, int'(TB_MASK), 1, "R1");
    push_exp(4, 0, 1, "R1");
    wait_n(2);

    // R2 direct enables, combined enable ignored
    rail_en_req = 3'b101; all_en_req = 1'b1;
    push_exp(0, 5, 1, "R2");
    push_exp(0, 5, 4, "R2");
    wait_n(5);
    rail_en_req = 3'b010;
    push_exp(0, 2, 1, "R2");
    wait_n(2);

    // R3 enable pin overrides everything
    en_pin = 1'b1;
    push_exp(0, 7, 1, "R3");
    wait_n(2);
    en_pin = 1'b0; rail_en_req = '0; all_en_req = 1'b0;
    push_exp(0, 0, 1, "R3");
    wait_n(3);

    // R4 sequencer with gap 2
    step_gap = 8'd2; all_en_req = 1'b1;
    push_exp(0, 0, 1, "R4");
    push_exp(0, 1, seq_lat(0, 2), "R4");
    push_exp(0, 1, seq_lat(1, 2) - 1, "R4");
    push_exp(0, 3, seq_lat(1, 2), "R4");
    push_exp(0, 3, seq_lat(2, 2) - 1, "R4");
    push_exp(0, 7, seq_lat(2, 2), "R4");
    push_exp(0, 7, seq_lat(2, 2) + 3, "R4");
    wait_n(12);

    // R5 withdrawal aborts, restart from rail A with gap 0
    all_en_req = 1'b0;
    push_exp(0, 7, 1, "R5");
    push_exp(0, 0, 2, "R5");
    wait_n(3);
    step_gap = 8'd0; all_en_req = 1'b1;
    push_exp(0, 1, seq_lat(0, 0), "R4");
    push_exp(0, 3, seq_lat(1, 0), "R4");
    push_exp(0, 7, seq_lat(2, 0), "R4");
    wait_n(6);

    // R5/R7 thermal abort mid-sequence with gap 3
    all_en_req = 1'b0;
    wait_n(3);
    step_gap = 8'd3; all_en_req = 1'b1;
    push_exp(0, 1, seq_lat(0, 3), "R5");
    wait_n(3);
    therm_event = 1'b1;
    push_exp(2, 1, 1, "R6");
    push_exp(0, 0, 2, "R7");
    push_exp(0, 0, 6, "R7");
    wait_n(1);
    therm_event = 1'b0;
    wait_n(2);
    rail_en_req = 3'b011;
    push_exp(0, 0, 1, "R7");
    wait_n(2);
    rail_en_req = '0;
    therm_event = 1'b1; therm_clr = 1'b1;
    push_exp(2, 1, 1, "R6");
    wait_n(1);
    therm_event = 1'b0;
    push_exp(2, 0, 1, "R6");
    push_exp(0, 0, 1, "R5");
    push_exp(0, 1, 3, "R5");
    wait_n(1);
    therm_clr = 1'b0;
    wait_n(3);
    all_en_req = 1'b0;
    push_exp(0, 0, 2, "R5");
    wait_n(4);

    // R8/R9 ready output
    pgood_in = 3'b011;
    push_exp(4, 3, 1, "R8");
    wait_n(3);
    force_ready = 1'b1;
    push_exp(1, 0, 1, "R9");
    push_exp(1, 1, 2, "R8");
    wait_n(3);
    pgood_in = 3'b001;
    push_exp(4, 1, 1, "R8");
    push_exp(1, 1, 1, "R8");
    push_exp(1, 0, 2, "R8");
    wait_n(3);

    // R10 mask write
    mask_wr = 1'b1; mask_wdata = 3'b110;
    push_exp(3, 6, 1, "R10");
    push_exp(1, 1, 2, "R10");
    wait_n(1);
    mask_wr = 1'b0; mask_wdata = '0;
    wait_n(3);

    force_ready = 1'b0;
    push_exp(1, 1, 1, "R9");
    push_exp(1, 0, 2, "R9");
    wait_n(3);
    en_pin = 1'b1;
    push_exp(0, 7, 1, "R3");
    push_exp(1, 0, 1, "R9");
    push_exp(1, 1, 2, "R8");
    wait_n(3);
    en_pin = 1'b0;
    push_exp(1, 0, 2, "R8");
    wait_n(4);

    // R9 sources changing every cycle keep ready frozen
    for (int k = 0; k < 4; k++) begin
      force_ready = ~force_ready;
      push_exp(1, 0, 1, "R9");
      wait_n(1);
    end
    force_ready = 1'b1;
    push_exp(1, 0, 1, "R9");
    push_exp(1, 1, 2, "R9");
    wait_n(4);

    while (q_due.size() > 0) wait_n(1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule